// File: doc/BRIEF.md
# L1 Cache Line Maintenance Unit

This unit sits between a core's auxiliary register port and the maintenance port of its level-one instruction and data caches. Software writes small registers. The unit turns each command write into array requests. A per-line command produces one request that carries a set index and a physical line tag. A whole-cache command produces one request for every set and way. The tag and data arrays do the actual discard or write-back work. The unit only forms the addresses, picks the operation and paces the requests.

Two addressing modes decide where the index and the tag come from. In the direct mode, the command value is the physical address. Its unused line-offset bits carry the virtual index bits that lie above the page boundary. In the split mode, a separate tag register holds the physical address. The command value is then the virtual address used for indexing, and the command executes when that value is written. A wide-address mode adds eight upper tag bits from a high-tag register, which software writes before the command. A control bit selects what a data-cache invalidate does: a plain discard, or write-back followed by discard.

The array port is valid/ready. A request stays on the port, unchanged, until the array raises ready. The unit then either drops the request or moves on to the next line of a walk. The register port stalls through `reg_wait`. A write offered while an operation is in progress is held until the unit goes idle. A read of the instruction-cache control register is also held while a whole instruction-cache invalidate runs. All other reads answer at once.

Top module: `l1_maint_unit`

## Requirements
- R1: Register offsets on `reg_addr`: 0 icache control, 1 dcache control (bit0 invalidate-writes-back select, bit1 write-back busy, read only), 2 mode (bit0 split addressing, bit1 wide address), 3 icache line invalidate, 4 dcache line invalidate, 5 dcache line write-back, 6 icache tag, 7 dcache tag, 8 icache high tag, 9 dcache high tag, 10 icache whole invalidate, 11 dcache whole invalidate, 12 dcache whole write-back; written configuration and tag values read back at their offsets, other offsets read 0.
- R2: In direct mode a line command value V gives `req_tag` low bits V[31:5] and `req_index` = {V[0], V[12:5]} (the line-offset bits carry the virtual bits above the 8 KiB page).
- R3: In split mode a line command value V gives `req_index` = V[13:5], and `req_tag` low bits come from bits [31:5] of that cache's tag register.
- R4: With wide mode on, `req_tag` bits [34:27] equal that cache's high-tag register; with it off they are 0.
- R5: Operation codes on `req_op` are 01 discard, 10 write back, 11 write back then discard; `req_icache` is 1 only for icache commands; a dcache invalidate (line or whole) uses 11 when control bit0 is 1 and 01 otherwise.
- R6: A whole-cache command with write data bit0 = 1 issues exactly 2^(9+1) requests with `req_whole` = 1, tag 0, ordered set-major and way-minor from {set 0, way 0} upward; writing 0 issues nothing.
- R7: Dcache control bit1 reads 1 from the cycle after a dcache write-back or write-back-then-discard command is accepted until its last request is accepted, and 0 while an icache operation runs.
- R8: A read of icache control during a whole icache invalidate is held with `reg_wait` until the walk ends, then returns 0.
- R9: Any register write offered while an operation is in progress is held with `reg_wait`, is not lost, and executes after the current operation in issue order.
- R10: A request held without `req_ready` keeps all its fields stable, and a line command issues exactly one request.
- R11: After reset no request is valid, `reg_wait` is 0 and the configuration registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, held while `reg_wait` is 1 |
| reg_rd_en | input | 1 | Register read strobe, held while `reg_wait` is 1 |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_wait | output | 1 | Stall for the access being offered |
| req_valid | output | 1 | Array request valid |
| req_ready | input | 1 | Array accepts the request |
| req_icache | output | 1 | 1 selects the instruction cache |
| req_op | output | 2 | Operation code |
| req_whole | output | 1 | Request belongs to a whole-cache walk |
| req_index | output | 9 | Set index |
| req_way | output | 1 | Way, meaningful during a walk |
| req_tag | output | 35 | Physical line address (tag) |

## Verification
Two events can land in the same cycle: a stalled register write and the acknowledge that ends the previous operation. The bench parks a command behind an unacknowledged request, then frees the array. It checks that the parked command comes out once, after the first, with its own fields. A read of the instruction-cache control register is issued in the same way against a running walk. It must return only after the final acknowledge, and the bench counts that all walk requests went out by then. A full sweep covers both addressing modes, both tag widths, both invalidate settings and all three line commands.

// File: rtl/l1m_pkg.sv
package l1m_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_ICTL     = 4'd0;
  localparam logic [REG_AW-1:0] A_DCTL     = 4'd1;
  localparam logic [REG_AW-1:0] A_MODE     = 4'd2;
  localparam logic [REG_AW-1:0] A_ILN_INV  = 4'd3;
  localparam logic [REG_AW-1:0] A_DLN_INV  = 4'd4;
  localparam logic [REG_AW-1:0] A_DLN_WB   = 4'd5;
  localparam logic [REG_AW-1:0] A_ITAG     = 4'd6;
  localparam logic [REG_AW-1:0] A_DTAG     = 4'd7;
  localparam logic [REG_AW-1:0] A_ITAG_HI  = 4'd8;
  localparam logic [REG_AW-1:0] A_DTAG_HI  = 4'd9;
  localparam logic [REG_AW-1:0] A_IALL_INV = 4'd10;
  localparam logic [REG_AW-1:0] A_DALL_INV = 4'd11;
  localparam logic [REG_AW-1:0] A_DALL_WB  = 4'd12;

  localparam logic [1:0] OP_DISCARD    = 2'b01;
  localparam logic [1:0] OP_WB         = 2'b10;
  localparam logic [1:0] OP_WB_DISCARD = 2'b11;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LINE = 2'd1,
    S_WALK = 2'd2
  } seq_state_t;
endpackage

// File: rtl/l1m_regs.sv
module l1m_regs
  import l1m_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PA_HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_wait,
  input  logic                 busy,
  input  logic                 iwhole_busy,
  input  logic                 flush_busy,
  output logic                 cmd_go,
  output logic                 cmd_icache,
  output logic [1:0]           cmd_op,
  output logic                 cmd_whole,
  output logic [DATA_W-1:0]    cmd_value,
  output logic                 mode_split,
  output logic                 mode_wide,
  output logic [DATA_W-1:0]    sel_tag,
  output logic [PA_HI_W-1:0]   sel_tag_hi
);
  logic               inv_wb_q;
  logic               split_q, wide_q;
  logic [DATA_W-1:0]  itag_q, dtag_q;
  logic [PA_HI_W-1:0] itag_hi_q, dtag_hi_q;
  logic               wr_ok;
  logic               is_cmd;

  // stall: any write while busy, icache control read while a walk invalidates
  assign reg_wait = (reg_wr_en && busy) ||
                    (reg_rd_en && reg_addr == A_ICTL && iwhole_busy);
  assign wr_ok    = reg_wr_en && !busy;

  always_comb begin
    is_cmd     = 1'b0;
    cmd_icache = 1'b0;
    cmd_op     = OP_DISCARD;
    cmd_whole  = 1'b0;
    case (reg_addr)
      A_ILN_INV:  begin is_cmd = 1'b1; cmd_icache = 1'b1; end
      A_DLN_INV:  begin is_cmd = 1'b1; cmd_op = inv_wb_q ? OP_WB_DISCARD : OP_DISCARD; end
      A_DLN_WB:   begin is_cmd = 1'b1; cmd_op = OP_WB; end
      A_IALL_INV: begin is_cmd = reg_wdata[0]; cmd_icache = 1'b1; cmd_whole = 1'b1; end
      A_DALL_INV: begin
        is_cmd    = reg_wdata[0];
        cmd_whole = 1'b1;
        cmd_op    = inv_wb_q ? OP_WB_DISCARD : OP_DISCARD;
      end
      A_DALL_WB:  begin is_cmd = reg_wdata[0]; cmd_whole = 1'b1; cmd_op = OP_WB; end
      default: ;
    endcase
  end

  assign cmd_go     = wr_ok && is_cmd;
  assign cmd_value  = reg_wdata;
  assign mode_split = split_q;
  assign mode_wide  = wide_q;
  assign sel_tag    = cmd_icache ? itag_q : dtag_q;
  assign sel_tag_hi = cmd_icache ? itag_hi_q : dtag_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_wb_q  <= 1'b0;
      split_q   <= 1'b0;
      wide_q    <= 1'b0;
      itag_q    <= '0;
      dtag_q    <= '0;
      itag_hi_q <= '0;
      dtag_hi_q <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        A_DCTL:    inv_wb_q <= reg_wdata[0];
        A_MODE:    begin split_q <= reg_wdata[0]; wide_q <= reg_wdata[1]; end
        A_ITAG:    itag_q <= reg_wdata;
        A_DTAG:    dtag_q <= reg_wdata;
        A_ITAG_HI: itag_hi_q <= reg_wdata[PA_HI_W-1:0];
        A_DTAG_HI: dtag_hi_q <= reg_wdata[PA_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ICTL:    reg_rdata[0] = iwhole_busy;
      A_DCTL:    begin reg_rdata[0] = inv_wb_q; reg_rdata[1] = flush_busy; end
      A_MODE:    begin reg_rdata[0] = split_q; reg_rdata[1] = wide_q; end
      A_ITAG:    reg_rdata = itag_q;
      A_DTAG:    reg_rdata = dtag_q;
      A_ITAG_HI: reg_rdata[PA_HI_W-1:0] = itag_hi_q;
      A_DTAG_HI: reg_rdata[PA_HI_W-1:0] = dtag_hi_q;
      default: ;
    endcase
  end

  p_write_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && busy) |-> reg_wait);

  p_ictl_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == A_ICTL && iwhole_busy) |-> reg_wait);

  p_no_cmd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_go);
endmodule

// File: rtl/l1m_addr.sv
module l1m_addr #(
  parameter int DATA_W  = 32,
  parameter int PA_HI_W = 8,
  parameter int OFS_W   = 5,
  parameter int SET_W   = 9,
  parameter int PAGE_W  = 13,
  localparam int TAG_W   = DATA_W + PA_HI_W - OFS_W,
  localparam int ALIAS_W = OFS_W + SET_W - PAGE_W
) (
  input  logic [DATA_W-1:0]  value,
  input  logic               split,
  input  logic               wide,
  input  logic [DATA_W-1:0]  ptag,
  input  logic [PA_HI_W-1:0] ptag_hi,
  output logic [SET_W-1:0]   index,
  output logic [TAG_W-1:0]   tag
);
  logic [DATA_W-OFS_W-1:0] tag_lo;
  logic [PA_HI_W-1:0]      tag_hi;
  logic [SET_W-1:0]        direct_index;
  logic                    unused_bits;

  assign tag_lo = split ? ptag[DATA_W-1:OFS_W] : value[DATA_W-1:OFS_W];
  assign tag_hi = wide ? ptag_hi : '0;
  assign tag    = {tag_hi, tag_lo};

  generate
    if (ALIAS_W > 0) begin : g_alias
      // virtual bits above the page ride in the line-offset field
      assign direct_index = {value[ALIAS_W-1:0], value[PAGE_W-1:OFS_W]};
    end else begin : g_plain
      assign direct_index = value[OFS_W+SET_W-1:OFS_W];
    end
  endgenerate

  assign index = split ? value[OFS_W+SET_W-1:OFS_W] : direct_index;

  assign unused_bits = ^{ptag[OFS_W-1:0], value[OFS_W-1:0]};
endmodule

// File: rtl/l1m_seq.sv
module l1m_seq
  import l1m_pkg::*;
#(
  parameter int SET_W = 9,
  parameter int WAY_W = 1,
  parameter int TAG_W = 35,
  localparam int CNT_W = SET_W + WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_icache,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_whole,
  input  logic [SET_W-1:0] cmd_index,
  input  logic [TAG_W-1:0] cmd_tag,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_icache,
  output logic [1:0]       req_op,
  output logic             req_whole,
  output logic [SET_W-1:0] req_index,
  output logic [WAY_W-1:0] req_way,
  output logic [TAG_W-1:0] req_tag,
  output logic             busy,
  output logic             iwhole_busy,
  output logic             flush_busy
);
  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             icache_q;
  logic [1:0]       op_q;
  logic [SET_W-1:0] index_q;
  logic [TAG_W-1:0] tag_q;
  logic             last_line;
  logic             hs;

  assign hs        = req_valid && req_ready;
  assign last_line = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      icache_q <= 1'b0;
      op_q     <= OP_DISCARD;
      index_q  <= '0;
      tag_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_go) begin
          st_q     <= cmd_whole ? S_WALK : S_LINE;
          cnt_q    <= '0;
          icache_q <= cmd_icache;
          op_q     <= cmd_op;
          index_q  <= cmd_index;
          tag_q    <= cmd_tag;
        end
        S_LINE: if (req_ready) st_q <= S_IDLE;
        S_WALK: if (req_ready) begin
          if (last_line) st_q <= S_IDLE;
          else           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign req_valid   = busy;
  assign req_whole   = (st_q == S_WALK);
  assign req_icache  = icache_q;
  assign req_op      = op_q;
  assign req_index   = req_whole ? cnt_q[CNT_W-1:WAY_W] : index_q;
  assign req_way     = req_whole ? cnt_q[WAY_W-1:0] : '0;
  assign req_tag     = req_whole ? '0 : tag_q;
  assign iwhole_busy = req_whole && icache_q;
  assign flush_busy  = busy && !icache_q && op_q[1];

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_way)
                                   && $stable(req_tag) && $stable(req_op)
                                   && $stable(req_icache) && $stable(req_whole)));

  p_line_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !req_whole) |=> !req_valid);

  p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_whole && !last_line) |=>
      (req_whole && {req_index, req_way} == $past({req_index, req_way}) + 1'b1));

  p_walk_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_whole) |-> ({req_index, req_way} == '0));
endmodule

// File: rtl/l1_maint_unit.sv
module l1_maint_unit
  import l1m_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PA_HI_W = 8,
  parameter int OFS_W   = 5,
  parameter int SET_W   = 9,
  parameter int WAY_W   = 1,
  parameter int PAGE_W  = 13,
  localparam int TAG_W  = DATA_W + PA_HI_W - OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_wait,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_icache,
  output logic [1:0]         req_op,
  output logic               req_whole,
  output logic [SET_W-1:0]   req_index,
  output logic [WAY_W-1:0]   req_way,
  output logic [TAG_W-1:0]   req_tag
);
  logic               busy, iwhole_busy, flush_busy;
  logic               cmd_go, cmd_icache, cmd_whole;
  logic [1:0]         cmd_op;
  logic [DATA_W-1:0]  cmd_value, sel_tag;
  logic [PA_HI_W-1:0] sel_tag_hi;
  logic               mode_split, mode_wide;
  logic [SET_W-1:0]   cmd_index;
  logic [TAG_W-1:0]   cmd_tag;

  l1m_regs #(.DATA_W(DATA_W), .PA_HI_W(PA_HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
    .busy(busy), .iwhole_busy(iwhole_busy), .flush_busy(flush_busy),
    .cmd_go(cmd_go), .cmd_icache(cmd_icache), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .cmd_value(cmd_value),
    .mode_split(mode_split), .mode_wide(mode_wide),
    .sel_tag(sel_tag), .sel_tag_hi(sel_tag_hi)
  );

  l1m_addr #(.DATA_W(DATA_W), .PA_HI_W(PA_HI_W), .OFS_W(OFS_W),
             .SET_W(SET_W), .PAGE_W(PAGE_W)) u_addr (
    .value(cmd_value), .split(mode_split), .wide(mode_wide),
    .ptag(sel_tag), .ptag_hi(sel_tag_hi),
    .index(cmd_index), .tag(cmd_tag)
  );

  l1m_seq #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_icache(cmd_icache), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .cmd_index(cmd_index), .cmd_tag(cmd_tag),
    .req_valid(req_valid), .req_ready(req_ready), .req_icache(req_icache),
    .req_op(req_op), .req_whole(req_whole), .req_index(req_index),
    .req_way(req_way), .req_tag(req_tag),
    .busy(busy), .iwhole_busy(iwhole_busy), .flush_busy(flush_busy)
  );

  p_flush_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> (req_valid && !req_icache && req_op[1]));

  p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !req_valid);
endmodule

// File: tb/test_l1_maint_unit.sv
`timescale 1ns/100ps
module test_l1_maint_unit;
  localparam int LINES = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_wait;
  logic        req_valid, req_icache, req_whole;
  logic        req_ready = 1'b0;
  logic [1:0]  req_op;
  logic [8:0]  req_index;
  logic [0:0]  req_way;
  logic [34:0] req_tag;

  int n_chk = 0, n_fail = 0;
  int hs_cnt = 0, walk_pos = 0, walk_err = 0;
  logic [47:0] last_rec = '0, prev_rec = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        rdy_hold = 1'b0;
  logic        ended = 1'b0;

  l1_maint_unit i_l1_maint_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_wait(reg_wait), .req_valid(req_valid), .req_ready(req_ready),
    .req_icache(req_icache), .req_op(req_op), .req_whole(req_whole),
    .req_index(req_index), .req_way(req_way), .req_tag(req_tag)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    req_ready = rdy_hold ? 1'b0 : (lfsr[0] | lfsr[2]);
  end

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      hs_cnt++;
      prev_rec = last_rec;
      last_rec = {req_icache, req_op, req_whole, req_index, req_tag};
      if (req_whole) begin
        if ({req_index, req_way} != 10'(walk_pos) || req_tag != '0) walk_err++;
        walk_pos++;
      end
    end
  end

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    while (reg_wait) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1;
    while (reg_wait) begin @(negedge clk); #1; end
    d = reg_rdata;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
  endtask

  task automatic wait_hs(input int target);
    int guard = 0;
    while (hs_cnt < target && guard < 20000) begin @(negedge clk); guard++; end
    @(posedge clk); #1;
  endtask

  function automatic logic [47:0] exp_line(input int c, input bit split, input bit wide,
                                           input bit im, input logic [31:0] v,
                                           input logic [31:0] p, input logic [7:0] h);
    logic [8:0]  idx;
    logic [34:0] tg;
    logic [1:0]  op;
    idx = split ? v[13:5] : {v[0], v[12:5]};
    tg  = {wide ? h : 8'h00, split ? p[31:5] : v[31:5]};
    op  = (c == 0) ? 2'b01 : (c == 1) ? (im ? 2'b11 : 2'b01) : 2'b10;
    return {(c == 0), op, 1'b0, idx, tg};
  endfunction

  function automatic logic [3:0] cmd_reg(input int c);
    return (c == 0) ? 4'd3 : (c == 1) ? 4'd4 : 4'd5;
  endfunction

  task automatic whole(input logic [3:0] a, input logic [3:0] exp_hdr, input string rq);
    int h0;
    h0 = hs_cnt; walk_pos = 0; walk_err = 0;
    wr(a, 32'h1);
    wait_hs(h0 + LINES);
    chk(walk_pos == LINES && walk_err == 0, rq, 64'(walk_pos), 64'(LINES));
    chk(last_rec[47:44] == exp_hdr, rq, 64'(last_rec[47:44]), 64'(exp_hdr));
  endtask

  initial begin
    logic [31:0] d;
    int h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(req_valid == 1'b0 && reg_wait == 1'b0, "R11", {62'b0, req_valid, reg_wait}, 64'h0);
    rd(4'd1, d); chk(d == 32'h0, "R11 dctl", 64'(d), 64'h0);
    rd(4'd2, d); chk(d == 32'h0, "R11 mode", 64'(d), 64'h0);

    // R1 readback of configuration and tags
    wr(4'd6, 32'hDEAD_BEEF); rd(4'd6, d); chk(d == 32'hDEAD_BEEF, "R1 itag", 64'(d), 64'hDEADBEEF);
    wr(4'd9, 32'h0000_01A7); rd(4'd9, d); chk(d == 32'h0000_00A7, "R1 dtag_hi", 64'(d), 64'hA7);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d); chk(d == 32'h3, "R1 mode", 64'(d), 64'h3);
    rd(4'd13, d); chk(d == 32'h0, "R1 unmapped", 64'(d), 64'h0);

    // R2 R3 R4 R5 sweep of modes and line commands
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 2; m++)
          for (int c = 0; c < 3; c++)
            for (int k = 0; k < 4; k++) begin
              logic [31:0] v, p;
              logic [7:0]  h;
              logic [47:0] e;
              v = 32'h9E37_79B9 * 32'(k * 7 + c * 3 + m * 11 + w * 5 + t * 13 + 1);
              v[0] = k[0];
              p = (v * 32'h0019_660D) ^ 32'h5A3C_96F1;
              h = 8'(k * 29 + c * 7 + w * 3 + t + 1);
              wr(4'd2, {30'b0, w[0], t[0]});
              wr(4'd1, {31'b0, m[0]});
              wr(4'd6, p); wr(4'd7, p);
              wr(4'd8, {24'b0, h}); wr(4'd9, {24'b0, h});
              h0 = hs_cnt;
              wr(cmd_reg(c), v);
              wait_hs(h0 + 1);
              e = exp_line(c, t[0], w[0], m[0], v, p, h);
              chk(last_rec == e && hs_cnt == h0 + 1,
                  t ? "R3 R4 R5 split line" : "R2 R4 R5 direct line", 64'(last_rec), 64'(e));
            end

    // R6 zero write to a whole register is ignored
    h0 = hs_cnt;
    wr(4'd11, 32'h0);
    repeat (5) @(negedge clk);
    chk(hs_cnt == h0 && req_valid == 1'b0, "R6 zero write", 64'(hs_cnt - h0), 64'h0);

    // R6 R5 whole dcache invalidate with both settings, whole write-back
    wr(4'd1, 32'h0); whole(4'd11, 4'b0011, "R6 R5 dall_inv im0");
    wr(4'd1, 32'h1); whole(4'd11, 4'b0111, "R6 R5 dall_inv im1");

    // R7 write-back busy bit across a whole write-back
    h0 = hs_cnt; walk_pos = 0; walk_err = 0;
    wr(4'd12, 32'h1);
    rd(4'd1, d); chk(d[1] == 1'b1, "R7 busy set", 64'(d), 64'h3);
    wait_hs(h0 + LINES);
    rd(4'd1, d); chk(d[1] == 1'b0, "R7 busy clear", 64'(d), 64'h1);
    chk(walk_pos == LINES && walk_err == 0 && last_rec[47:44] == 4'b0101, "R6 dall_wb",
        64'(walk_pos), 64'(LINES));

    // R8 icache control read stalls over a whole icache invalidate; R7 negative
    h0 = hs_cnt; walk_pos = 0; walk_err = 0;
    wr(4'd10, 32'h1);
    rd(4'd1, d); chk(d[1] == 1'b0, "R7 icache no busy", 64'(d), 64'h1);
    rd(4'd0, d);
    chk(d == 32'h0 && hs_cnt == h0 + LINES, "R8 stall", 64'(hs_cnt - h0), 64'(LINES));
    chk(walk_err == 0 && last_rec[47:44] == 4'b1011, "R6 iall_inv", 64'(last_rec[47:44]), 64'hB);

    // R9 R10 write parked behind an unaccepted request
    wr(4'd2, 32'h0);
    rdy_hold = 1'b1;
    @(posedge clk); #1;
    h0 = hs_cnt;
    wr(4'd5, 32'h1234_5640);
    fork
      wr(4'd3, 32'h8765_4321);
      begin
        repeat (4) @(negedge clk);
        #1;
        chk(reg_wait == 1'b1 && req_valid == 1'b1, "R9 held", {62'b0, reg_wait, req_valid}, 64'h3);
        chk(hs_cnt == h0, "R10 no accept", 64'(hs_cnt - h0), 64'h0);
        rdy_hold = 1'b0;
      end
    join
    wait_hs(h0 + 2);
    chk(prev_rec == exp_line(2, 1'b0, 1'b0, 1'b1, 32'h1234_5640, 32'h0, 8'h0), "R9 first",
        64'(prev_rec), 64'(exp_line(2, 1'b0, 1'b0, 1'b1, 32'h1234_5640, 32'h0, 8'h0)));
    chk(last_rec == exp_line(0, 1'b0, 1'b0, 1'b1, 32'h8765_4321, 32'h0, 8'h0) && hs_cnt == h0 + 2,
        "R9 R10 second", 64'(last_rec), 64'(exp_line(0, 1'b0, 1'b0, 1'b1, 32'h8765_4321, 32'h0, 8'h0)));

    repeat (4) @(posedge clk);
    summary();
  end
endmodule